// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter Stage

This block is one 4-bit counting stage that a parameter builds as either a decimal counter (modulo 10) or a binary counter (modulo 16). There is no direction control line. Instead, the stage has two separate count clocks. A rising edge on the up clock adds one to the count, and a rising edge on the down clock subtracts one. An edge only counts while the other clock is held high. An active-high master clear forces the count to zero. An active-low load input copies a 4-bit parallel word into the count.

The count clocks are slow external signals. The stage does not clock its flops with them. It samples both of them with a fast system clock, passes each through a synchronizer, and detects the rising edge. Every flop therefore runs on one clock. Two active-low outputs signal the ends of the range. Terminal-up goes low while the count is at its top value and the up clock is low. Terminal-down goes low while the count is zero and the down clock is low. To chain stages, wire one stage's terminal-up to the next stage's up clock and its terminal-down to the next stage's down clock. No other glue logic is needed.

Top module: `updn_counter_stage`

## Requirements
- R1: With DECIMAL=0 the count runs 0..15, and counting up from 15 gives 0. With DECIMAL=1 it runs 0..9: counting up from 9 gives 0, and counting down from 0 gives 9. In both modes, counting down from 0 gives the top value.
- R2: While `clr` is high, `q` is 0 at once, without waiting for a system clock edge. This holds whatever the count clocks and `load_n` do.
- R3: While `clr` is low and `load_n` is low, `q` takes the value of `data` at each system clock edge. It follows changes to `data` one clock later.
- R4: A rising edge on `up_clk` while `dn_clk` is high raises `q` by one step. `q` changes on the third system clock edge after the input changes.
- R5: A rising edge on `dn_clk` while `up_clk` is high lowers `q` by one step, with the same timing as R4.
- R6: An edge on either count clock while the other count clock is low leaves `q` unchanged.
- R7: `carry_n` is low only while `q` is at or above the top value (9 in decimal mode, 15 in binary mode) and the synchronized `up_clk` level is low. It falls on the second system clock edge after `up_clk` falls. It rises on the second system clock edge after `up_clk` rises, one edge before `q` wraps.
- R8: `borrow_n` is low only while `q` is 0 and the synchronized `dn_clk` level is low. It has the same two-edge timing relative to `dn_clk` as R7.
- R9: In a chain, stage k's `carry_n` drives stage k+1's `up_clk`, and its `borrow_n` drives stage k+1's `dn_clk`. Such a chain counts as one multi-digit counter in the chosen radix.
- R10: Priority runs clear, then load, then count. A count-clock edge that arrives while `clr` is high or `load_n` is low is dropped. It does not take effect after release.
- R11: In decimal mode, a loaded value from 10 to 15 counts up to the next 4-bit value (15 goes to 0) and counts down by one. Any value of 9 or above drives `carry_n` low while `up_clk` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| clr | input | 1 | Master clear, active high, asynchronous |
| load_n | input | 1 | Parallel load enable, active low |
| data | input | WIDTH | Parallel load word |
| up_clk | input | 1 | Count-up clock; rising edge counts |
| dn_clk | input | 1 | Count-down clock; rising edge counts |
| q | output | WIDTH | Current count |
| carry_n | output | 1 | Terminal-up, active low |
| borrow_n | output | 1 | Terminal-down, active low |

## Verification
The bench drives a binary pair of stages and a decimal pair of stages from the same stimulus and compares both against a model that works one digit at a time.

- **Full up and down sweeps** past 255 and 99 separate per-digit wrap errors from errors in the hand-off between stages.
- **Loaded values 10 to 15 in decimal mode** separate the "at or above 9" terminal test from a plain equality test.
- **Clock-by-clock sampling of `carry_n`, `borrow_n` and `q`** around a single pulse shows whether the synchronizer depth and the release edge are right.
- **Pulses given while the other count clock is low, under clear, or under load** show whether gated or masked edges leak through late.

// File: rtl/updn_stage_pkg.sv
package updn_stage_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_UP   = 2'd2,
        ACT_DN   = 2'd3
    } stage_act_e;

endpackage

// File: rtl/updn_edge_sync.sv
module updn_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    generate
        if (STAGES > 1) begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], async_in};
        end else begin : g_single
            always_comb sync_d = async_in;
        end
    endgenerate

    always_comb prev_d = sync_q[STAGES-1];

    // idle level of a count clock is high; clearing to 1 avoids a false edge
    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign level = sync_q[STAGES-1];
    assign rise  = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/updn_step_logic.sv
module updn_step_logic #(
    parameter bit DECIMAL = 1'b0,
    parameter int WIDTH   = 4
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt_up,
    output logic [WIDTH-1:0] nxt_dn,
    output logic             at_top,
    output logic             at_zero
);
    localparam logic [WIDTH-1:0] TOP = DECIMAL ? WIDTH'(9) : {WIDTH{1'b1}};

    always_comb begin
        at_top  = (cur >= TOP);
        at_zero = (cur == '0);
        nxt_up  = (cur == TOP) ? '0 : WIDTH'(cur + 1'b1);
        nxt_dn  = at_zero ? TOP : WIDTH'(cur - 1'b1);
    end
endmodule

// File: rtl/updn_counter_stage.sv
module updn_counter_stage
    import updn_stage_pkg::*;
#(
    parameter bit DECIMAL     = 1'b0,
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load_n,
    input  logic [WIDTH-1:0] data,
    input  logic             up_clk,
    input  logic             dn_clk,
    output logic [WIDTH-1:0] q,
    output logic             carry_n,
    output logic             borrow_n
);
    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } stage_state_t;

    stage_state_t st_d, st_q;
    stage_act_e   act;

    logic             up_lvl, up_rise, dn_lvl, dn_rise;
    logic [WIDTH-1:0] step_up, step_dn;
    logic             at_top, at_zero;

    updn_edge_sync #(.STAGES(SYNC_STAGES)) up_sync_i (
        .clk(clk), .clr(clr), .async_in(up_clk), .level(up_lvl), .rise(up_rise)
    );

    updn_edge_sync #(.STAGES(SYNC_STAGES)) dn_sync_i (
        .clk(clk), .clr(clr), .async_in(dn_clk), .level(dn_lvl), .rise(dn_rise)
    );

    updn_step_logic #(.DECIMAL(DECIMAL), .WIDTH(WIDTH)) step_i (
        .cur(st_q.cnt), .nxt_up(step_up), .nxt_dn(step_dn),
        .at_top(at_top), .at_zero(at_zero)
    );

    always_comb begin
        st_d = st_q;
        act  = ACT_HOLD;
        if (!load_n)                act = ACT_LOAD;
        else if (up_rise && dn_lvl) act = ACT_UP;
        else if (dn_rise && up_lvl) act = ACT_DN;
        case (act)
            ACT_LOAD: st_d.cnt = data;
            ACT_UP:   st_d.cnt = step_up;
            ACT_DN:   st_d.cnt = step_dn;
            default:  st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) st_q <= '0;
        else     st_q <= st_d;
    end

    assign q        = st_q.cnt;
    assign carry_n  = ~(at_top & ~up_lvl);
    assign borrow_n = ~(at_zero & ~dn_lvl);
endmodule

// File: rtl/updn_counter_checker.sv
module updn_counter_checker #(
    parameter bit DECIMAL = 1'b0,
    parameter int WIDTH   = 4
) (
    input logic             clk,
    input logic             clr,
    input logic             load_n,
    input logic [WIDTH-1:0] data,
    input logic [WIDTH-1:0] q,
    input logic             carry_n,
    input logic             borrow_n
);
    localparam logic [WIDTH-1:0] TOP = DECIMAL ? WIDTH'(9) : {WIDTH{1'b1}};

    function automatic logic [WIDTH-1:0] ref_up(input logic [WIDTH-1:0] v);
        return (v == TOP) ? '0 : WIDTH'(v + 1'b1);
    endfunction

    function automatic logic [WIDTH-1:0] ref_dn(input logic [WIDTH-1:0] v);
        return (v == '0) ? TOP : WIDTH'(v - 1'b1);
    endfunction

    // R2
    clr_zero_chk: assert property (@(posedge clk) clr |-> (q == '0));

    // R3
    load_track_chk: assert property (@(posedge clk) disable iff (clr)
        (!load_n) |=> (q == $past(data)));

    // R7
    carry_top_chk: assert property (@(posedge clk) disable iff (clr)
        (!carry_n) |-> (q >= TOP));

    // R8
    borrow_zero_chk: assert property (@(posedge clk) disable iff (clr)
        (!borrow_n) |-> (q == '0));

    // R4 R5
    single_step_chk: assert property (@(posedge clk) disable iff (clr)
        ($past(load_n) && !$past(clr) && (q != $past(q)))
            |-> ((q == ref_up($past(q))) || (q == ref_dn($past(q)))));
endmodule

bind updn_counter_stage updn_counter_checker #(.DECIMAL(DECIMAL), .WIDTH(WIDTH)) chk_i (
    .clk(clk), .clr(clr), .load_n(load_n), .data(data),
    .q(q), .carry_n(carry_n), .borrow_n(borrow_n)
);

// File: tb/updn_counter_stage_tb.sv
module updn_counter_stage_tb_top;
    logic clk = 1'b0;
    logic clr = 1'b1;
    logic load_n = 1'b1;
    logic up_in = 1'b1;
    logic dn_in = 1'b1;
    logic [7:0] bdata = '0;
    logic [7:0] ddata = '0;

    logic [3:0] b0_q, b1_q, d0_q, d1_q;
    logic b0_c, b0_b, b1_c, b1_b, d0_c, d0_b, d1_c, d1_b;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    logic [7:0] m_bin = '0;
    logic [3:0] m_dlo = '0;
    logic [3:0] m_dhi = '0;

    always #10 clk = ~clk;

    updn_counter_stage #(.DECIMAL(1'b0)) dut_i (
        .clk(clk), .clr(clr), .load_n(load_n), .data(bdata[3:0]),
        .up_clk(up_in), .dn_clk(dn_in), .q(b0_q), .carry_n(b0_c), .borrow_n(b0_b));
    updn_counter_stage #(.DECIMAL(1'b0)) b_hi_i (
        .clk(clk), .clr(clr), .load_n(load_n), .data(bdata[7:4]),
        .up_clk(b0_c), .dn_clk(b0_b), .q(b1_q), .carry_n(b1_c), .borrow_n(b1_b));
    updn_counter_stage #(.DECIMAL(1'b1)) d_lo_i (
        .clk(clk), .clr(clr), .load_n(load_n), .data(ddata[3:0]),
        .up_clk(up_in), .dn_clk(dn_in), .q(d0_q), .carry_n(d0_c), .borrow_n(d0_b));
    updn_counter_stage #(.DECIMAL(1'b1)) d_hi_i (
        .clk(clk), .clr(clr), .load_n(load_n), .data(ddata[7:4]),
        .up_clk(d0_c), .dn_clk(d0_b), .q(d1_q), .carry_n(d1_c), .borrow_n(d1_b));

    // op[9:8]: 0 up pulse, 1 down pulse, 2 load byte, 3 clear
    localparam int NVEC = 14;
    localparam logic [9:0] VEC [NVEC] = '{
        {2'd2, 8'h5A}, {2'd0, 8'h00}, {2'd0, 8'h00}, {2'd1, 8'h00},
        {2'd2, 8'h09}, {2'd0, 8'h00}, {2'd1, 8'h00}, {2'd2, 8'hFE},
        {2'd0, 8'h00}, {2'd0, 8'h00}, {2'd1, 8'h00}, {2'd3, 8'h00},
        {2'd1, 8'h00}, {2'd2, 8'hC3}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " binary chain"}, {24'd0, b1_q, b0_q}, {24'd0, m_bin});
        chk({tag, " decimal chain"}, {24'd0, d1_q, d0_q}, {24'd0, m_dhi, m_dlo});
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic void model_up();
        logic c;
        m_bin = m_bin + 8'd1;
        c     = (m_dlo >= 4'd9);
        m_dlo = (m_dlo == 4'd9) ? 4'd0 : m_dlo + 4'd1;
        if (c) m_dhi = (m_dhi == 4'd9) ? 4'd0 : m_dhi + 4'd1;
    endfunction

    function automatic void model_dn();
        logic b;
        m_bin = m_bin - 8'd1;
        b     = (m_dlo == 4'd0);
        m_dlo = b ? 4'd9 : m_dlo - 4'd1;
        if (b) m_dhi = (m_dhi == 4'd0) ? 4'd9 : m_dhi - 4'd1;
    endfunction

    task automatic pulse_up();
        @(negedge clk) up_in = 1'b0;
        wait_n(6);
        up_in = 1'b1;
        wait_n(8);
        model_up();
    endtask

    task automatic pulse_dn();
        @(negedge clk) dn_in = 1'b0;
        wait_n(6);
        dn_in = 1'b1;
        wait_n(8);
        model_dn();
    endtask

    task automatic load_byte(input logic [7:0] v);
        @(negedge clk);
        bdata = v; ddata = v; load_n = 1'b0;
        wait_n(2);
        load_n = 1'b1;
        wait_n(2);
        m_bin = v; m_dlo = v[3:0]; m_dhi = v[7:4];
    endtask

    task automatic do_clear();
        @(negedge clk) clr = 1'b1;
        wait_n(2);
        clr = 1'b0;
        wait_n(2);
        m_bin = '0; m_dlo = '0; m_dhi = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        // R2 reset state
        check_all("R2 reset state");
        chk("R2 reset carry", {31'd0, b0_c}, 32'd1);
        clr = 1'b0;
        wait_n(3);

        // vector table: R1 R4 R5 R9 R11
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i][9:8])
                2'd0: pulse_up();
                2'd1: pulse_dn();
                2'd2: load_byte(VEC[i][7:0]);
                default: do_clear();
            endcase
            check_all("R9 table step");
        end

        // R1 R9 full sweeps through every wrap point
        load_byte(8'h00);
        for (int k = 0; k < 257; k++) begin
            pulse_up();
            check_all("R1 up sweep");
        end
        for (int k = 0; k < 257; k++) begin
            pulse_dn();
            check_all("R1 down sweep");
        end

        // R7 R11 R4 carry timing, decimal lo digit loaded with illegal 15
        load_byte(8'h9F);
        @(negedge clk) up_in = 1'b0;
        @(negedge clk);
        chk("R7 carry still high after 1 edge", {31'd0, b0_c}, 32'd1);
        @(negedge clk);
        chk("R7 carry low at top", {31'd0, b0_c}, 32'd0);
        chk("R11 decimal carry low at illegal 15", {31'd0, d0_c}, 32'd0);
        up_in = 1'b1;
        @(negedge clk);
        chk("R7 carry low before release", {31'd0, b0_c}, 32'd0);
        @(negedge clk);
        chk("R7 carry released", {31'd0, b0_c}, 32'd1);
        chk("R4 count not yet changed", {28'd0, b0_q}, 32'd15);
        @(negedge clk);
        chk("R4 count wraps on third edge", {28'd0, b0_q}, 32'd0);
        wait_n(6);
        model_up();
        check_all("R11 R9 after illegal carry");

        // R8 borrow timing
        load_byte(8'h00);
        @(negedge clk) dn_in = 1'b0;
        @(negedge clk);
        chk("R8 borrow high after 1 edge", {31'd0, b0_b}, 32'd1);
        @(negedge clk);
        chk("R8 borrow low at zero", {31'd0, b0_b}, 32'd0);
        dn_in = 1'b1;
        wait_n(2);
        chk("R8 borrow released", {31'd0, b0_b}, 32'd1);
        wait_n(6);
        model_dn();
        check_all("R5 R8 down wrap");

        // R6 gated edges
        load_byte(8'h35);
        @(negedge clk) dn_in = 1'b0;
        wait_n(4);
        up_in = 1'b0; wait_n(6); up_in = 1'b1; wait_n(8);
        check_all("R6 up edge with down low ignored");
        dn_in = 1'b1;
        wait_n(8);
        model_dn();
        check_all("R5 down edge after release");
        @(negedge clk) up_in = 1'b0;
        wait_n(4);
        dn_in = 1'b0; wait_n(6); dn_in = 1'b1; wait_n(8);
        check_all("R6 down edge with up low ignored");
        up_in = 1'b1;
        wait_n(8);
        model_up();
        check_all("R4 up edge after release");

        // R2 R10 clear in mid count
        @(negedge clk) up_in = 1'b0;
        wait_n(4);
        clr = 1'b1;
        @(negedge clk);
        chk("R2 clear mid count binary", {28'd0, b0_q}, 32'd0);
        chk("R2 clear mid count decimal", {28'd0, d0_q}, 32'd0);
        up_in = 1'b1;
        wait_n(4);
        clr = 1'b0;
        wait_n(8);
        m_bin = '0; m_dlo = '0; m_dhi = '0;
        check_all("R10 edge under clear dropped");

        // R3 R10 load in mid count
        @(negedge clk) up_in = 1'b0;
        wait_n(4);
        bdata = 8'h77; ddata = 8'h77; load_n = 1'b0;
        wait_n(2);
        chk("R3 load value", {24'd0, b1_q, b0_q}, 32'h77);
        bdata = 8'h12; ddata = 8'h12;
        wait_n(2);
        chk("R3 load follows data", {24'd0, d1_q, d0_q}, 32'h12);
        up_in = 1'b1;
        wait_n(6);
        load_n = 1'b1;
        wait_n(4);
        m_bin = 8'h12; m_dlo = 4'h2; m_dhi = 4'h1;
        check_all("R10 edge under load dropped");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule